// File: doc/BRIEF.md
# Serial Link Reset and Codec Enumeration Controller

This block sits on the controller side of a serial codec link. It holds the link in reset until software sets a run bit, then records which codecs announce themselves. Each serial data-in line has a status-change strobe, and the codec attached to line *n* answers at address *n*. A strobe seen while the link runs sets a sticky status bit whose index equals that codec address. Software clears status bits by writing ones. A frame tick input stands in for link frame timing: the block counts frames after reset release and raises a read-only flag once the settling window in which late codecs may still report has passed.

An interrupt-enable bit gates a level interrupt request. The request is high while any status bit is set, which covers both initial enumeration and later hot-plug events such as a docking codec. Registers are reached through a small select/write/read port with combinational read data.

Top module: `codec_link_enum`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, link_rst_n, enum_done and irq are 0 and every register selector reads 0x0000. Selector 3 is reserved: it always reads 0x0000 and writes to it change nothing.
- R2: A write to selector 0 (link control) with bit 0 = 1 drives link_rst_n to 1 from the next cycle. A write with bit 0 = 0 drives it back to 0. Bit 0 of selector 0 reads back the same value.
- R3: enum_done (also bit 8 of selector 0) becomes 1 once SETTLE_FRAMES frame_tick pulses have been sampled while the link was released, and then stays 1. It is 0 whenever link_rst_n is 0, and the frame count restarts at each release.
- R4: A one-cycle pulse on line_chg[n] while the link is released sets status bit n, read at selector 1 bit n. For example, pulses on lines 0 and 2 read as 0x0005.
- R5: Status bits are all cleared one cycle after the link returns to reset and stay cleared while it is held there. line_chg pulses sampled while in reset are ignored.
- R6: A write to selector 1 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. If a new pulse arrives on the same line in the same cycle, that bit stays set.
- R7: Selector 2 bit 0 is the interrupt enable. irq equals, one cycle later, the enable ANDed with "any status bit set". With the enable at 0, status still records events but irq stays 0.
- R8: A pulse on a line whose status bit is already set leaves the status value unchanged and does not make irq toggle. A fresh interrupt for that line needs the bit to be cleared first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per link frame |
| line_chg | input | NUM_LINES | Per-line status-change strobe, index = codec address |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register selector: 0 control, 1 status, 2 interrupt control, 3 reserved |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_sel (combinational) |
| link_rst_n | output | 1 | Link reset line, 1 = released |
| enum_done | output | 1 | Settling window elapsed since release |
| irq | output | 1 | Interrupt request (level) |

## Verification
The bench builds the block with its defaults: 15 lines and a 25-frame window. At these values the highest codec address (line 14) can be driven, and the window boundary can be tested exactly, at 24 versus 25 counted ticks, in a short run. A behavioural model with integer state runs beside the design and is compared against every output and the selected read data on every clock. This exposes off-by-one errors in the frame count, in the write-one-to-clear race and in the one-cycle interrupt latency. Directed checks cover reserved-selector writes, ticks counted while the link is in reset, and enumeration after the link is released a second time.

// File: rtl/codec_enum_pkg.sv
package codec_enum_pkg;
  localparam int REG_DW = 16;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_LINK_CTL = 2'd0,
    SEL_STATUS   = 2'd1,
    SEL_IRQ_CTL  = 2'd2,
    SEL_RSVD     = 2'd3
  } reg_sel_e;

  localparam int RUN_BIT  = 0;
  localparam int DONE_BIT = 8;
  localparam int IE_BIT   = 0;
endpackage

// File: rtl/cle_reset_seq.sv
module cle_reset_seq #(
  parameter int SETTLE_FRAMES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_wr,
  input  logic run_wdata,
  input  logic frame_tick,
  output logic run_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(SETTLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_FRAMES);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    run_d = run_q;
    if (run_wr) run_d = run_wdata;
  end

  assign cnt_en = run_q && frame_tick && (cnt_q != CNT_END);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_q)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o  = run_q;
  assign done_o = run_q && (cnt_q == CNT_END);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_END);
  p_cnt_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == '0));
  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && run_d) |=> done_o);
endmodule

// File: rtl/cle_status_track.sv
module cle_status_track #(
  parameter int NUM_LINES = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic [NUM_LINES-1:0] line_chg,
  input  logic                 clr_en,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] stat_o,
  output logic                 any_o
);
  logic [NUM_LINES-1:0] stat_q, stat_d;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic keep, hit;
    assign keep = stat_q[i] && !(clr_en && clr_mask[i]);
    assign hit  = line_chg[i];
    always_comb begin
      stat_d[i] = 1'b0;
      if (run_i) stat_d[i] = keep || hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
  assign any_o  = |stat_q;

  p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (stat_q == '0));
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_en) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  p_set_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (line_chg != '0)) |=> ((stat_q & $past(line_chg)) == $past(line_chg)));
endmodule

// File: rtl/cle_irq_gen.sv
module cle_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ie_wr,
  input  logic ie_wdata,
  input  logic any_i,
  output logic ie_o,
  output logic irq_o
);
  logic ie_q, ie_d;
  logic irq_q, irq_d;

  always_comb begin
    ie_d = ie_q;
    if (ie_wr) ie_d = ie_wdata;
    irq_d = ie_q && any_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      irq_q <= irq_d;
    end
  end

  assign ie_o  = ie_q;
  assign irq_o = irq_q;

  p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ie_q));
  p_irq_needs_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(any_i));
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q && any_i) |=> irq_q);
endmodule

// File: rtl/codec_link_enum.sv
module codec_link_enum
  import codec_enum_pkg::*;
#(
  parameter int NUM_LINES     = 15,
  parameter int SETTLE_FRAMES = 25
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic [NUM_LINES-1:0] line_chg,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [15:0]          reg_wdata,
  output logic [15:0]          reg_rdata,
  output logic                 link_rst_n,
  output logic                 enum_done,
  output logic                 irq
);
  logic                 wr_ctl, wr_stat, wr_ie;
  logic                 run, done, ie, any_stat;
  logic [NUM_LINES-1:0] stat;
  reg_sel_e             sel;

  assign sel     = reg_sel_e'(reg_sel);
  assign wr_ctl  = reg_wr && (sel == SEL_LINK_CTL);
  assign wr_stat = reg_wr && (sel == SEL_STATUS);
  assign wr_ie   = reg_wr && (sel == SEL_IRQ_CTL);

  cle_reset_seq #(.SETTLE_FRAMES(SETTLE_FRAMES)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_wr(wr_ctl), .run_wdata(reg_wdata[RUN_BIT]),
    .frame_tick(frame_tick), .run_o(run), .done_o(done));

  cle_status_track #(.NUM_LINES(NUM_LINES)) u_stat (
    .clk(clk), .rst_n(rst_n), .run_i(run), .line_chg(line_chg),
    .clr_en(wr_stat), .clr_mask(reg_wdata[NUM_LINES-1:0]),
    .stat_o(stat), .any_o(any_stat));

  cle_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .ie_wr(wr_ie), .ie_wdata(reg_wdata[IE_BIT]),
    .any_i(any_stat), .ie_o(ie), .irq_o(irq));

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_LINK_CTL: begin
        reg_rdata[RUN_BIT]  = run;
        reg_rdata[DONE_BIT] = done;
      end
      SEL_STATUS:  reg_rdata[NUM_LINES-1:0] = stat;
      SEL_IRQ_CTL: reg_rdata[IE_BIT] = ie;
      default:     reg_rdata = '0;
    endcase
  end

  assign link_rst_n = run;
  assign enum_done  = done;

  p_done_needs_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enum_done |-> link_rst_n);
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (link_rst_n == $past(reg_wdata[RUN_BIT])));
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_RSVD) |-> (reg_rdata == '0));
endmodule

// File: tb/codec_link_enum_bench.sv
module codec_link_enum_bench;
  localparam int NL = 15;
  localparam int SF = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_tick = 1'b0;
  logic [NL-1:0] line_chg = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic          link_rst_n, enum_done, irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  codec_link_enum #(.NUM_LINES(NL), .SETTLE_FRAMES(SF)) u_codec_link_enum (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .line_chg(line_chg),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .link_rst_n(link_rst_n), .enum_done(enum_done), .irq(irq));

  // behavioural reference model
  int m_run, m_cnt, m_stat, m_ie, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_stat = 0; m_ie = 0; m_irq = 0;
    end else begin
      int n_run, n_cnt, n_stat, n_ie, n_irq;
      n_run = m_run; n_ie = m_ie;
      if (reg_wr && reg_sel == 2'd0) n_run = reg_wdata[0];
      if (reg_wr && reg_sel == 2'd2) n_ie = reg_wdata[0];
      n_cnt = m_cnt;
      if (m_run == 0) n_cnt = 0;
      else if (frame_tick && m_cnt < SF) n_cnt = m_cnt + 1;
      if (m_run == 0) n_stat = 0;
      else begin
        n_stat = m_stat;
        if (reg_wr && reg_sel == 2'd1) n_stat = n_stat & ~int'(reg_wdata[NL-1:0]);
        n_stat = n_stat | int'(line_chg);
      end
      n_irq = (m_ie != 0 && m_stat != 0) ? 1 : 0;
      m_run = n_run; m_cnt = n_cnt; m_stat = n_stat; m_ie = n_ie; m_irq = n_irq;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    int m_done, exp_rd;
    if (!finished) begin
      cycles++;
      m_done = (m_run != 0 && m_cnt == SF) ? 1 : 0;
      chk("R2 link_rst_n", link_rst_n, m_run);
      chk("R3 enum_done", enum_done, m_done);
      chk("R7 irq", irq, m_irq);
      case (reg_sel)
        2'd0: exp_rd = (m_done << 8) | m_run;
        2'd1: exp_rd = m_stat;
        2'd2: exp_rd = m_ie;
        default: exp_rd = 0;
      endcase
      chk("R4 reg_rdata model", reg_rdata, exp_rd);
      if (cycles > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask
  task automatic wr(input int sel, input int data);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = sel[1:0]; reg_wdata = data[15:0];
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask
  task automatic pulse(input int mask);
    @(posedge clk); #1; line_chg = mask[NL-1:0];
    @(posedge clk); #1; line_chg = '0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; frame_tick = 1'b1;
      @(posedge clk); #1; frame_tick = 1'b0;
    end
  endtask
  task automatic rd(input int sel, input int exp, input string tag);
    @(posedge clk); #1; reg_sel = sel[1:0];
    @(negedge clk); #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #20;
    @(negedge clk);
    chk("R1 reset link_rst_n", link_rst_n, 0);
    chk("R1 reset irq", irq, 0);
    rst_n = 1'b1;
    rd(0, 0, "R1 ctl after reset");
    rd(1, 0, "R1 status after reset");
    rd(2, 0, "R1 irqctl after reset");
    // events and ticks in reset are ignored
    pulse(5); ticks(3); idle(2);
    rd(1, 0, "R5 status ignores events in reset");
    chk("R3 no done in reset", enum_done, 0);
    // release
    wr(0, 1); idle(1);
    chk("R2 released", link_rst_n, 1);
    rd(0, 1, "R2 run bit readback");
    wr(2, 1);
    pulse(5); idle(2);
    rd(1, 5, "R4 lines 0 and 2 -> 0x0005");
    chk("R7 irq raised", irq, 1);
    pulse(1); idle(2);
    rd(1, 5, "R8 repeat event unchanged");
    chk("R8 irq still high", irq, 1);
    // settle window
    ticks(SF - 1); idle(1);
    chk("R3 not done at window-1", enum_done, 0);
    ticks(1); idle(1);
    chk("R3 done at window", enum_done, 1);
    rd(0, 16'h0101, "R3 done bit readback");
    ticks(4);
    chk("R3 done stays", enum_done, 1);
    // write-one-to-clear
    wr(1, 1); idle(1);
    rd(1, 4, "R6 clear bit 0 only");
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 16'h0004; line_chg = 15'h0004;
    @(posedge clk); #1;
    reg_wr = 1'b0; line_chg = '0;
    rd(1, 4, "R6 new event wins over clear");
    wr(1, 4); idle(2);
    rd(1, 0, "R6 all cleared");
    chk("R7 irq drops", irq, 0);
    // interrupt disabled, highest address
    wr(2, 0);
    pulse(1 << 14); idle(2);
    rd(1, 16'h4000, "R4 line 14 sets bit 14");
    chk("R7 irq masked", irq, 0);
    wr(2, 1); idle(2);
    chk("R7 irq after enable", irq, 1);
    // back to reset
    wr(0, 0); idle(2);
    rd(1, 0, "R5 status cleared in reset");
    chk("R2 link reset asserted", link_rst_n, 0);
    chk("R3 done cleared", enum_done, 0);
    chk("R7 irq cleared", irq, 0);
    wr(3, 16'hFFFF);
    rd(3, 0, "R1 reserved reads zero");
    rd(0, 0, "R1 reserved write no effect");
    // second release restarts counting
    wr(0, 1);
    ticks(SF - 1); idle(1);
    chk("R3 restart count", enum_done, 0);
    ticks(1); idle(1);
    chk("R3 done after second release", enum_done, 1);
    idle(3);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule